// File: doc/BRIEF.md
# Coalescing Store Buffer with Burst Builder

This block sits between a write-through data cache and a bus master port. The cache pushes each store into it as an address, a data word and byte enables. The block holds up to eight such stores in arrival order. It drains them onto the bus as write packets and allows only one transaction in flight at a time. When a packet starts, the block counts how many stores at the head of the queue form an unbroken run of successive word addresses that stays inside one 4 KB page. It sends that whole run as one burst, and each request beat reports the burst length.

Stores leave the queue only after the bus has returned the single response for their packet. A response that signals an error raises a flag that stays set, and the failed stores are discarded as usual. The `full` output stalls the cache. The `empty` output tells the cache that every store has been written, so a read can go out safely.

Top module: `store_coalesce_buf`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `req_valid` is 0 and `err_flag` is 0.
- R2: A store is accepted on a rising edge where `push_valid` is 1 and `full` is 0. `full` is 1 exactly while DEPTH stores are held. A store offered while `full` is 1 is dropped and never appears on the bus.
- R3: `empty` is 1 exactly when no store is held, counting the stores of a packet still awaiting its response. `empty` and `full` are never both 1, and no request is issued while `empty` is 1.
- R4: The burst length (`req_len`) is fixed when a packet starts. It equals the length of the leading run of held stores in which each address satisfies addr[31:2] = previous addr[31:2] + 1. Stores pushed after the start go into a later packet.
- R5: A run ends where addr[31:12] changes, so a store in the next 4 KB page starts a new packet even if its word address is successive.
- R6: Beat k of a packet carries the address, data and byte enables of the k-th oldest store, with k starting at 0. `req_len` is constant for the whole packet, and `req_last` is 1 on the final beat only.
- R7: While `req_valid` is 1 and `req_ready` is 0, all request outputs hold their values.
- R8: After the final beat of a packet is accepted, no request is issued until `rsp_valid` has been seen.
- R9: On `rsp_valid`, the stores of the outstanding packet are retired. If `rsp_error` is 1 at that time, `err_flag` becomes 1 and stays 1 until reset. The stores are retired either way.
- R10: A push can be accepted on the same edge as a request beat, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Store offered by the cache |
| push_addr | input | 32 | Byte address of the store |
| push_data | input | 32 | Store data |
| push_be | input | 4 | Byte enables of the store |
| full | output | 1 | Buffer holds DEPTH stores; producer must stall |
| empty | output | 1 | No store pending or in flight |
| req_valid | output | 1 | Write request beat valid |
| req_ready | input | 1 | Bus accepts the current beat |
| req_addr | output | 32 | Beat address |
| req_data | output | 32 | Beat data |
| req_be | output | 4 | Beat byte enables |
| req_len | output | 4 | Number of beats in the current packet |
| req_last | output | 1 | Final beat of the packet |
| rsp_valid | input | 1 | Write response for the outstanding packet |
| rsp_error | input | 1 | Response reports an error |
| err_flag | output | 1 | Sticky write error indicator |

## Verification
The bound checker watches every cycle for several properties:
- request stability under back-pressure;
- the absence of any beat while a response is pending;
- the position of `req_last` against `req_len`;
- successive, same-page addresses inside a packet;
- the stickiness of the error flag and the exclusion of `empty` with `full`.

Some behaviours can only be shown by the directed scenarios, because they depend on what was queued when a packet began. These include the exact burst lengths chosen for a given queue content, the split at a page edge, the dropping of a store offered while full, the overlap of a push with a beat, and the retirement of stores after an error.

// File: rtl/scb_pkg.sv
package scb_pkg;

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] data;
        logic [3:0]  be;
    } scb_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_WAIT = 2'd2
    } scb_state_e;

endpackage

// File: rtl/scb_entry_store.sv
module scb_entry_store
    import scb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  scb_entry_t wr_entry,
    input  logic [PTR_W-1:0] head_ptr,
    output scb_entry_t ordered [DEPTH]
);

    scb_entry_t slots_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots_q[wr_ptr] <= wr_entry;
        end
    end

    // Present the slots oldest first, starting at the head pointer.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rot
        assign ordered[gi] = slots_q[head_ptr + PTR_W'(gi)];
    end

endmodule

// File: rtl/scb_run_scan.sv
module scb_run_scan #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [31:0]      addr_ord [DEPTH],
    input  logic [CNT_W-1:0] held,
    output logic [CNT_W-1:0] run_len
);

    logic [DEPTH-1:0] chain;

    assign chain[0] = 1'b1;
    for (genvar gi = 1; gi < DEPTH; gi++) begin : g_link
        assign chain[gi] =
            (addr_ord[gi][31:2] == addr_ord[gi-1][31:2] + 30'd1) &&
            (addr_ord[gi][31:12] == addr_ord[gi-1][31:12]);
    end

    always_comb begin
        logic alive;
        alive   = 1'b1;
        run_len = (held != '0) ? CNT_W'(1) : '0;
        for (int i = 1; i < DEPTH; i++) begin
            if (alive && (CNT_W'(i) < held) && chain[i]) begin
                run_len = CNT_W'(i + 1);
            end else begin
                alive = 1'b0;
            end
        end
    end

endmodule

// File: rtl/store_coalesce_buf.sv
module store_coalesce_buf
    import scb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [31:0]      push_addr,
    input  logic [31:0]      push_data,
    input  logic [3:0]       push_be,
    output logic             full,
    output logic             empty,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [31:0]      req_addr,
    output logic [31:0]      req_data,
    output logic [3:0]       req_be,
    output logic [CNT_W-1:0] req_len,
    output logic             req_last,
    input  logic             rsp_valid,
    input  logic             rsp_error,
    output logic             err_flag
);

    typedef struct packed {
        scb_state_e       state;
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] beat;
        logic [CNT_W-1:0] len;
        logic             err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    scb_entry_t       ordered [DEPTH];
    logic [31:0]      addr_ord [DEPTH];
    logic [CNT_W-1:0] run_len;
    logic             push_ok;
    scb_entry_t       cur;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_addr
        assign addr_ord[gi] = ordered[gi].addr;
    end

    assign push_ok = push_valid && (ctl_q.count != CNT_W'(DEPTH));

    scb_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .wr_en    (push_ok),
        .wr_ptr   (ctl_q.tail),
        .wr_entry ('{addr: push_addr, data: push_data, be: push_be}),
        .head_ptr (ctl_q.head),
        .ordered  (ordered)
    );

    scb_run_scan #(.DEPTH(DEPTH)) u_scan (
        .addr_ord (addr_ord),
        .held     (ctl_q.count),
        .run_len  (run_len)
    );

    always_comb begin
        logic [CNT_W-1:0] pop_n;
        ctl_d = ctl_q;
        pop_n = '0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (ctl_q.count != '0) begin
                    ctl_d.len   = run_len;
                    ctl_d.beat  = '0;
                    ctl_d.state = ST_SEND;
                end
            end
            ST_SEND: begin
                if (req_ready) begin
                    if (ctl_q.beat == ctl_q.len - CNT_W'(1)) begin
                        ctl_d.state = ST_WAIT;
                    end else begin
                        ctl_d.beat = ctl_q.beat + CNT_W'(1);
                    end
                end
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    pop_n       = ctl_q.len;
                    ctl_d.head  = ctl_q.head + PTR_W'(ctl_q.len);
                    ctl_d.err   = ctl_q.err | rsp_error;
                    ctl_d.state = ST_IDLE;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        if (push_ok) begin
            ctl_d.tail = ctl_q.tail + PTR_W'(1);
        end
        ctl_d.count = ctl_q.count + CNT_W'(push_ok) - pop_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cur       = ordered[ctl_q.beat[PTR_W-1:0]];
    assign req_valid = (ctl_q.state == ST_SEND);
    assign req_addr  = cur.addr;
    assign req_data  = cur.data;
    assign req_be    = cur.be;
    assign req_len   = ctl_q.len;
    assign req_last  = req_valid && (ctl_q.beat == ctl_q.len - CNT_W'(1));
    assign full      = (ctl_q.count == CNT_W'(DEPTH));
    assign empty     = (ctl_q.count == '0);
    assign err_flag  = ctl_q.err;

endmodule

// File: rtl/scb_chk.sv
module scb_chk #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             full,
    input logic             empty,
    input logic             req_valid,
    input logic             req_ready,
    input logic [31:0]      req_addr,
    input logic [31:0]      req_data,
    input logic [3:0]       req_be,
    input logic [CNT_W-1:0] req_len,
    input logic             req_last,
    input logic             rsp_valid,
    input logic             rsp_error,
    input logic             err_flag
);

    logic             wait_q;
    logic             mid_q;
    logic [CNT_W-1:0] nbeat_q;
    logic [31:0]      prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q  <= 1'b0;
            mid_q   <= 1'b0;
            nbeat_q <= '0;
            prev_q  <= '0;
        end else begin
            if (req_valid && req_ready) begin
                if (req_last) begin
                    wait_q  <= 1'b1;
                    mid_q   <= 1'b0;
                    nbeat_q <= '0;
                end else begin
                    mid_q   <= 1'b1;
                    nbeat_q <= nbeat_q + CNT_W'(1);
                    prev_q  <= req_addr;
                end
            end
            if (rsp_valid && wait_q) begin
                wait_q <= 1'b0;
            end
        end
    end

    // R8
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q |-> !req_valid);

    // R6
    last_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_last == (nbeat_q == req_len - CNT_W'(1))));

    // R6
    len_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_last) |=> (req_valid && $stable(req_len)));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_addr) && $stable(req_data) &&
             $stable(req_be) && $stable(req_last) && $stable(req_len)));

    // R4
    run_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_q && req_valid) |->
            ((req_addr[31:2] == prev_q[31:2] + 30'd1) &&
             (req_addr[31:12] == prev_q[31:12])));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    // R9
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_error && wait_q) |=> err_flag);

    // R3
    empty_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));

    // R3
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !req_valid);

    // R2
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_valid && !rsp_valid) |=> full);

endmodule

bind store_coalesce_buf scb_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .full       (full),
    .empty      (empty),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_data   (req_data),
    .req_be     (req_be),
    .req_len    (req_len),
    .req_last   (req_last),
    .rsp_valid  (rsp_valid),
    .rsp_error  (rsp_error),
    .err_flag   (err_flag)
);

// File: tb/store_coalesce_buf_tb_top.sv
module store_coalesce_buf_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [31:0] push_addr = '0;
    logic [31:0] push_data = '0;
    logic [3:0]  push_be = '0;
    logic        full, empty, req_valid, req_last, err_flag;
    logic        req_ready = 1'b1;
    logic [31:0] req_addr, req_data;
    logic [3:0]  req_be, req_len;
    logic        rsp_valid = 1'b0;
    logic        rsp_error = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    // bench-side bus model state
    logic        hold = 1'b0;
    logic        err_next = 1'b0;
    logic        stall_mode = 1'b0;
    int          lasts_seen = 0;
    int          rsps_sent = 0;
    int          overlap = 0;
    int          nb = 0;
    logic [31:0] b_addr [64];
    logic [31:0] b_data [64];
    logic [3:0]  b_be   [64];
    logic [3:0]  b_len  [64];
    logic        b_last [64];

    always #5 clk = ~clk;

    store_coalesce_buf dut_i (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_addr(push_addr), .push_data(push_data), .push_be(push_be),
        .full(full), .empty(empty),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_data(req_data),
        .req_be(req_be), .req_len(req_len), .req_last(req_last),
        .rsp_valid(rsp_valid), .rsp_error(rsp_error), .err_flag(err_flag)
    );

    // Monitor: inputs change just after a rising edge, so values seen at the
    // falling edge are those the next rising edge will act on.
    always @(negedge clk) begin
        if (rst_n && req_valid && req_ready) begin
            if (nb < 64) begin
                b_addr[nb] = req_addr; b_data[nb] = req_data; b_be[nb] = req_be;
                b_len[nb]  = req_len;  b_last[nb] = req_last;
            end
            nb = nb + 1;
            if (req_last) lasts_seen = lasts_seen + 1;
            if (push_valid && !full) overlap = overlap + 1;
        end
    end

    // Responder and ready driver
    initial begin
        forever begin
            @(posedge clk); #1;
            req_ready = stall_mode ? ~req_ready : 1'b1;
            if (rsp_valid) begin
                rsp_valid = 1'b0;
                rsp_error = 1'b0;
            end else if (lasts_seen != rsps_sent && !hold) begin
                rsp_valid = 1'b1;
                rsp_error = err_next;
                rsps_sent = rsps_sent + 1;
            end
        end
    end

    function automatic logic [31:0] dat_of(input logic [31:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [3:0] be_of(input logic [31:0] a);
        return (a[2] ? 4'h3 : 4'hF);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] a);
        push_valid = 1'b1; push_addr = a; push_data = dat_of(a); push_be = be_of(a);
        @(posedge clk); #1;
        push_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (empty && lasts_seen == rsps_sent && !rsp_valid) break;
        end
        @(negedge clk);
    endtask

    // Check one recorded beat against the expected store and packet shape.
    task automatic exp_beat(input int idx, input logic [31:0] a, input logic [3:0] len,
                            input logic last, input string req);
        check(idx < nb, req, nb, idx + 1);
        if (idx < nb) begin
            check(b_addr[idx] == a, req, b_addr[idx], a);
            check(b_data[idx] == dat_of(a) && b_be[idx] == be_of(a), req, b_data[idx], dat_of(a));
            check(b_len[idx] == len, req, b_len[idx], len);
            check(b_last[idx] == last, req, b_last[idx], last);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; hold = 1'b0; err_next = 1'b0; stall_mode = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        // R1
        check(empty == 1'b1, "R1 empty", empty, 1);
        check(full == 1'b0, "R1 full", full, 0);
        check(req_valid == 1'b0, "R1 req_valid", req_valid, 0);
        check(err_flag == 1'b0, "R1 err_flag", err_flag, 0);
    endtask

    task automatic t_singles();
        int base = nb;
        hold = 1'b1;
        push(32'h100);
        // R3: empty drops once a store is held
        @(negedge clk);
        check(empty == 1'b0, "R3 empty after push", empty, 0);
        push(32'h200); push(32'h300);
        repeat (6) @(negedge clk);
        // R8: the first packet is done; nothing new until its response
        check(req_valid == 1'b0 && lasts_seen == rsps_sent + 1, "R8 wait for response", req_valid, 0);
        hold = 1'b0;
        drain();
        check(nb - base == 3, "R6 beat count singles", nb - base, 3);
        exp_beat(base + 0, 32'h100, 4'd1, 1'b1, "R6 single");
        exp_beat(base + 1, 32'h200, 4'd1, 1'b1, "R4 non-successive");
        exp_beat(base + 2, 32'h300, 4'd1, 1'b1, "R4 non-successive");
        check(empty == 1'b1, "R3 empty after drain", empty, 1);
    endtask

    task automatic t_merge();
        int base = nb;
        int ov0 = overlap;
        hold = 1'b1;
        push(32'h1000);
        push(32'h2000); push(32'h2004); push(32'h2008); push(32'h200C);
        push(32'h3000);
        // R10: a push and the first packet's beat coincided
        check(overlap > ov0, "R10 push with beat", overlap - ov0, 1);
        hold = 1'b0;
        drain();
        // R4: first packet started alone, later stores formed a 4-beat run
        exp_beat(base + 0, 32'h1000, 4'd1, 1'b1, "R4 late join");
        exp_beat(base + 1, 32'h2000, 4'd4, 1'b0, "R4 run");
        exp_beat(base + 2, 32'h2004, 4'd4, 1'b0, "R6 order");
        exp_beat(base + 3, 32'h2008, 4'd4, 1'b0, "R6 order");
        exp_beat(base + 4, 32'h200C, 4'd4, 1'b1, "R6 last");
        exp_beat(base + 5, 32'h3000, 4'd1, 1'b1, "R4 run end");
    endtask

    task automatic t_page();
        int base = nb;
        hold = 1'b1;
        push(32'h8000);
        push(32'h4FF8); push(32'h4FFC); push(32'h5000); push(32'h5004);
        hold = 1'b0;
        drain();
        exp_beat(base + 0, 32'h8000, 4'd1, 1'b1, "R5 kick");
        exp_beat(base + 1, 32'h4FF8, 4'd2, 1'b0, "R5 page low");
        exp_beat(base + 2, 32'h4FFC, 4'd2, 1'b1, "R5 page end");
        exp_beat(base + 3, 32'h5000, 4'd2, 1'b0, "R5 page high");
        exp_beat(base + 4, 32'h5004, 4'd2, 1'b1, "R5 page high");
    endtask

    task automatic t_full();
        int base = nb;
        hold = 1'b1;
        push(32'h6000);
        for (int i = 0; i < 7; i++) push(32'h7000 + 32'(4 * i));
        @(negedge clk);
        check(full == 1'b1, "R2 full at depth", full, 1);
        push(32'h9000);
        @(negedge clk);
        check(full == 1'b1, "R2 still full", full, 1);
        stall_mode = 1'b1;
        hold = 1'b0;
        drain();
        stall_mode = 1'b0;
        check(nb - base == 8, "R2 dropped store absent", nb - base, 8);
        exp_beat(base + 0, 32'h6000, 4'd1, 1'b1, "R2 kick");
        for (int i = 0; i < 7; i++)
            exp_beat(base + 1 + i, 32'h7000 + 32'(4 * i), 4'd7, (i == 6), "R7 run under stall");
        check(full == 1'b0, "R2 full clears", full, 0);
    endtask

    task automatic t_error();
        err_next = 1'b1;
        push(32'hA000);
        drain();
        err_next = 1'b0;
        // R9
        check(err_flag == 1'b1, "R9 error sets flag", err_flag, 1);
        check(empty == 1'b1, "R9 entries retired on error", empty, 1);
        push(32'hB000);
        drain();
        check(err_flag == 1'b1, "R9 flag sticky", err_flag, 1);
        do_reset();
        check(err_flag == 1'b0, "R1 reset clears flag", err_flag, 0);
    endtask

    initial begin
        fork
            begin
                do_reset();
                t_reset();
                t_singles();
                t_merge();
                t_page();
                t_full();
                t_error();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk = n_chk + 1;
                n_bad = n_bad + 1;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule